// File: doc/BRIEF.md
# Digital Input Qualification Filter

This block prepares a raw, asynchronous digital input for use by on-chip logic that needs a clean level: a capture pin, a count-direction pin or an external clock pin. The input first crosses into the system clock domain through a two-stage synchronizer. The synchronized level is then sampled at a programmable rate. The qualified output moves to a new level only when six consecutive samples agree on it.

An 8-bit period field selects the sampling rate. A nonzero value n takes one sample every 2·n system clocks, so the rejection window grows with the setting. A value of zero turns the filter off, and the synchronized input then drives the output directly. Writing a different value to the field restarts the sampling count, so the new rate starts from a known phase.

Top module: `input_qualifier`

## Requirements
- R1: While reset is high, and on the first clock edge after it falls, the output is low. Reset clears the sample history and the sampling count.
- R2: With the period field at 0, an input level that is present at clock edge e appears at the output from edge e+2. Any level held for 2 or more clocks therefore appears for the same number of clocks.
- R3: With the period field at n (1 to 255), a sample is taken every 2·n clocks. This holds up to 510 clocks for n = 255.
- R4: A change of the period field restarts the count. If the new value is first present at edge E, samples are taken at edges E + k·2·n, for k = 1, 2, and so on.
- R5: A sample taken at edge T holds the input level that was present at edge T−2. The output takes a level on the same edge as the sixth consecutive sample of that level.
- R6: A pulse that covers no more than 5·2·n clock edges never changes the output.
- R7: When the last six samples are not all equal, the output holds its level. A single opposite sample inside a run restarts the count of six.
- R8: A pulse that covers 6·2·n clock edges always passes, whatever its phase against the samples. A pulse of 5·2·n+1 edges passes when its first edge is seen by a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| async_in | input | 1 | Raw input, asynchronous to clk |
| period_sel | input | 8 | Sampling period control: 0 turns the filter off, n selects a period of 2·n clocks |
| qual_out | output | 1 | Qualified, registered output level |

## Verification
The assertions assume that the period field changes only by deliberate writes, and that reset is held for several clocks so that every register has a known value before checking starts. The bench changes the field only through a task that starts each test. It holds reset for four clocks, and it moves the input level only just after a clock edge. Each test records the edge at which the new field value takes effect. Pulses are then placed at fixed offsets from that edge, so every sample position is known. The history is drained with idle-low samples before the next test.

// File: rtl/inq_pkg.sv
package inq_pkg;
    localparam int DEF_FIELD_W = 8;
    localparam int DEF_SAMPLES = 6;
    localparam int DEF_SYNC    = 2;

    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_SET  = 2'd1,
        DEC_CLR  = 2'd2
    } dec_e;
endpackage

// File: rtl/inq_sync.sv
module inq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
        if (rst) begin
            st_d.chain = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/inq_prescaler.sv
module inq_prescaler #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] period_sel,
    output logic               tick,
    output logic               bypass
);
    localparam int CNT_W = FIELD_W + 1;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic [CNT_W-1:0]   cnt;
    } pre_t;

    pre_t             st_q, st_d;
    logic [CNT_W-1:0] span;
    logic             chg;

    always_comb begin
        span   = {period_sel, 1'b0};
        bypass = (period_sel == '0);
        chg    = (period_sel != st_q.field);
        tick   = 1'b0;
        st_d       = st_q;
        st_d.field = period_sel;
        if (chg || bypass) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == span - 1'b1) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (rst) begin
            st_d.field = '0;
            st_d.cnt   = '0;
            tick       = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_CNT_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        (!chg && !bypass) |-> (st_q.cnt < span)); // R3

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        chg |=> ((st_q.cnt == '0) && !tick)); // R4
endmodule

// File: rtl/inq_history.sv
module inq_history
    import inq_pkg::*;
#(
    parameter int SAMPLES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic bypass,
    input  logic tick,
    input  logic sample,
    output logic qual
);
    typedef struct packed {
        logic [SAMPLES-1:0] hist;
        logic               qual;
    } hist_t;

    hist_t              st_q, st_d;
    logic [SAMPLES-1:0] window;
    dec_e               dec;

    always_comb begin
        window = {st_q.hist[SAMPLES-2:0], sample};
        if (&window) begin
            dec = DEC_SET;
        end else if (window == '0) begin
            dec = DEC_CLR;
        end else begin
            dec = DEC_HOLD;
        end

        st_d = st_q;
        if (bypass) begin
            st_d.qual = sample;
        end else if (tick) begin
            st_d.hist = window;
            case (dec)
                DEC_SET: st_d.qual = 1'b1;
                DEC_CLR: st_d.qual = 1'b0;
                default: st_d.qual = st_q.qual;
            endcase
        end
        if (rst) begin
            st_d.hist = '0;
            st_d.qual = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign qual = st_q.qual;

    AST_RISE_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q.qual) && !$past(bypass)) |-> (&st_q.hist)); // R5

    AST_FALL_ALL_ZEROS: assert property (@(posedge clk) disable iff (rst)
        ($fell(st_q.qual) && !$past(bypass)) |-> (st_q.hist == '0)); // R5

    AST_HOLD_BETWEEN_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !tick) |=> $stable(st_q.qual)); // R7
endmodule

// File: rtl/input_qualifier.sv
module input_qualifier
    import inq_pkg::*;
#(
    parameter int FIELD_W = DEF_FIELD_W,
    parameter int SAMPLES = DEF_SAMPLES,
    parameter int SYNC    = DEF_SYNC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               async_in,
    input  logic [FIELD_W-1:0] period_sel,
    output logic               qual_out
);
    logic synced;
    logic tick;
    logic bypass;

    inq_sync #(.STAGES(SYNC)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (async_in),
        .dout (synced)
    );

    inq_prescaler #(.FIELD_W(FIELD_W)) pre_i (
        .clk        (clk),
        .rst        (rst),
        .period_sel (period_sel),
        .tick       (tick),
        .bypass     (bypass)
    );

    inq_history #(.SAMPLES(SAMPLES)) hist_i (
        .clk    (clk),
        .rst    (rst),
        .bypass (bypass),
        .tick   (tick),
        .sample (synced),
        .qual   (qual_out)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !qual_out); // R1
endmodule

// File: tb/input_qualifier_tb.sv
`timescale 1ns/1ps
module input_qualifier_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [7:0] period_sel = 8'd3;
    logic       q_out;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t m_e;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    input_qualifier dut_i (
        .clk        (clk),
        .rst        (rst),
        .async_in   (din),
        .period_sel (period_sel),
        .qual_out   (q_out)
    );

    // monitor: pops expected items when their cycle is reached
    always @(negedge clk) begin
        if (!rst) begin
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                m_e = sb_q.pop_front();
                checks++;
                if (m_e.due != cyc || q_out !== m_e.val) begin
                    fails++;
                    $display("FAIL %s cycle %0d actual=%b expected=%b", m_e.tag, m_e.due, q_out, m_e.val);
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 60000 && !done) begin
            fails++;
            $display("FAIL watchdog cycle %0d actual=hung expected=finished", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic expect_at(input int due, input logic v, input string tag);
        exp_t e;
        e.due = due;
        e.val = v;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wait_to(input int e);
        while (cyc < e) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic set_period(input int n, output int base);
        @(posedge clk);
        #1;
        period_sel = n[7:0];
        base = cyc + 1;
    endtask

    // pulse placed 'off' edges after the edge seen by the first sample
    task automatic run_pulse(input int n, input int off, input int len,
                             input int rise_k, input int fall_k, input string tag);
        int p;
        int base;
        int a;
        p = 2 * n;
        set_period(n, base);
        a = base + p - 2 + off;
        if (rise_k > 0) begin
            expect_at(base + rise_k * p - 1, 1'b0, tag);
            expect_at(base + rise_k * p,     1'b1, tag);
            expect_at(base + fall_k * p - 1, 1'b1, tag);
            expect_at(base + fall_k * p,     1'b0, tag);
        end else begin
            expect_at(base + 6 * p,  1'b0, tag);
            expect_at(base + 7 * p,  1'b0, tag);
            expect_at(base + 10 * p, 1'b0, tag);
        end
        wait_to(a - 1);
        din = 1'b1;
        wait_to(a + len - 1);
        din = 1'b0;
        wait_to(base + 14 * p + 2);
    endtask

    // long pulse with one dip seen by the fourth sample (R7)
    task automatic run_glitch(input int n);
        int p;
        int base;
        int a;
        p = 2 * n;
        set_period(n, base);
        a = base + p - 2;
        expect_at(base + 6 * p,      1'b0, "R7");
        expect_at(base + 9 * p,      1'b0, "R7");
        expect_at(base + 10 * p,     1'b1, "R7");
        expect_at(base + 16 * p - 1, 1'b1, "R7");
        expect_at(base + 16 * p,     1'b0, "R7");
        wait_to(a - 1);
        din = 1'b1;
        wait_to(base + 4 * p - 3);
        din = 1'b0;
        wait_to(base + 4 * p - 2);
        din = 1'b1;
        wait_to(a + 10 * p - 1);
        din = 1'b0;
        wait_to(base + 18 * p + 2);
    endtask

    task automatic run_bypass(input int len, input string tag);
        int a;
        a = cyc + 4;
        expect_at(a + 1, 1'b0, tag);
        for (int i = 0; i < len; i++) begin
            expect_at(a + 2 + i, 1'b1, tag);
        end
        expect_at(a + len + 2, 1'b0, tag);
        wait_to(a - 1);
        din = 1'b1;
        wait_to(a + len - 1);
        din = 1'b0;
        wait_to(a + len + 6);
    endtask

    initial begin
        int b;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        expect_at(cyc + 1, 1'b0, "R1");
        expect_at(cyc + 3, 1'b0, "R1");
        wait_to(cyc + 4);

        run_pulse(1, 0, 11, 6, 12, "R5");       // 5P+1 aligned, P=2
        run_pulse(3, 1, 36, 7, 13, "R8");       // 6P, late phase
        run_glitch(2);
        run_pulse(3, 5, 36, 7, 13, "R8");       // 6P, latest phase
        run_pulse(255, 0, 2551, 6, 12, "R3");   // largest period, 510
        run_pulse(5, 0, 50, 0, 0, "R6");        // 5P never passes

        set_period(2, b);                       // R4: change mid-count
        wait_to(b + 2);
        run_pulse(4, 0, 41, 6, 12, "R4");

        set_period(0, b);                       // R2: filter off
        wait_to(b + 4);
        run_bypass(2, "R2");
        run_bypass(5, "R2");

        wait_to(cyc + 4);
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard pending actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule